// File: doc/BRIEF.md
# Mode-banked register file

This block is the integer register file of a small 32-bit RISC core whose visible register set depends on the current processor mode. The core presents a 5-bit mode field every cycle. The block translates each architectural register number r0 to r14 into a physical storage location chosen for that mode. The two combinational read ports feed the A and B operand buses. The single write port from the result bus commits on the rising clock edge.

The fast-interrupt mode owns a private group of seven registers, r8 to r14. The interrupt, supervisor, abort and undefined modes each own only their own stack pointer (r13) and link register (r14). User and system modes share the base set. The program counter lives in a dedicated register with its own write port, and index 15 on a read port returns it. Each of the five exception modes also has one saved status word, which is reachable only while that mode is active. The block does not decide when modes change. It only follows the mode it is given.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and all five saved status words are cleared to zero, and they read as zero after `rst` falls.
- R2: Both read ports are combinational and independent. An index of 0 to 14 returns the register mapped for the current mode, and index 15 returns the current program counter value.
- R3: A general write commits at the rising edge. A read of the same physical register in the cycle of the write returns the old value, and the new value is visible from the next cycle on.
- R4: User mode (10000) and system mode (11111) use the same physical registers. Any encoding not listed in R5, R6 or R7 is banked as user mode.
- R5: In fast-interrupt mode (10001), r8 to r14 are private copies. In this mode r0 to r7 are the user registers, and writes to r8 to r14 leave the user r8 to r14 unchanged.
- R6: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have a private r13 and r14. They share r0 to r12 with user mode, which means the user copy of r8 to r12 and not the fast-interrupt copy.
- R7: Each of the five exception modes has its own saved status word. It is read on `sr_rd_data` and written through `sr_wr_en`, and the write is visible from the next cycle on.
- R8: In user, system or any unlisted mode, `sr_rd_data` reads zero, and a saved status write has no effect on any stored word.
- R9: `pc_q` takes `pc_wr_data` at the edge where `pc_wr_en` is high. A general write addressed to index 15 is ignored and changes neither the program counter nor any general register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode field |
| rd_a_idx | input | 4 | Architectural index for operand port A |
| rd_a_data | output | 32 | Operand A data (combinational) |
| rd_b_idx | input | 4 | Architectural index for operand port B |
| rd_b_data | output | 32 | Operand B data (combinational) |
| wr_en | input | 1 | Result-bus write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | 32 | Result-bus write data |
| pc_q | output | 32 | Program counter value |
| pc_wr_en | input | 1 | Program counter write enable |
| pc_wr_data | input | 32 | Next program counter value |
| sr_rd_data | output | 32 | Saved status word of the current mode |
| sr_wr_en | input | 1 | Saved status write enable |
| sr_wr_data | input | 32 | Saved status write data |

## Verification
The bench first fills the user bank with values that encode the index. It then writes different tagged patterns through each exception mode, so that a wrong row in the mapping shows up as a value from the wrong bank and not only as a wrong number. After each mode's writes, reads back through the other modes separate a shared register from a private one, and the fast-interrupt r8 to r12 from the user copy. A write to index 15 is aimed so that a missing guard would corrupt the fast-interrupt r8 slot, and that slot is then read. Saved status writes in user and system mode are followed by rereads of all five exception words.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int PC_IDX          = 15;
  localparam int FIQ_LO          = 8;
  localparam int SP_IDX          = 13;
  localparam int FIQ_SIZE        = PC_IDX - FIQ_LO;
  localparam int SMALL_SIZE      = PC_IDX - SP_IDX;
  localparam int NUM_SMALL_BANKS = 4;
  localparam int NUM_SAVED       = NUM_SMALL_BANKS + 1;
  localparam int NUM_PHYS        = PC_IDX + FIQ_SIZE + NUM_SMALL_BANKS * SMALL_SIZE;

  function automatic bank_e bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return BK_FIQ;
      M_IRQ:   return BK_IRQ;
      M_SVC:   return BK_SVC;
      M_ABT:   return BK_ABT;
      M_UND:   return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic has_saved(input logic [4:0] m);
    return bank_of(m) != BK_USR;
  endfunction
endpackage

// File: rtl/rf_index_map.sv
`timescale 1ns/1ps
module rf_index_map
  import rf_pkg::*;
#(
  parameter int IW = 4,
  parameter int PW = 5
) (
  input  bank_e           bank_i,
  input  logic [IW-1:0]   arch_i,
  output logic [PW-1:0]   phys_o,
  output logic            pc_sel_o
);
  int a;
  int p;

  always_comb begin
    a = int'(arch_i);
    p = a;
    if (bank_i == BK_FIQ && a >= FIQ_LO && a < PC_IDX) begin
      p = PC_IDX + (a - FIQ_LO);
    end else if (bank_i != BK_USR && bank_i != BK_FIQ && a >= SP_IDX && a < PC_IDX) begin
      p = PC_IDX + FIQ_SIZE + (int'(bank_i) - int'(BK_IRQ)) * SMALL_SIZE + (a - SP_IDX);
    end
    phys_o   = PW'(p);
    pc_sel_o = (a == PC_IDX);
  end
endmodule

// File: rtl/rf_gpr_mem.sv
`timescale 1ns/1ps
module rf_gpr_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 30,
  parameter int PW    = 5,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [PW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][PW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end
endmodule

// File: rtl/rf_saved_status.sv
`timescale 1ns/1ps
module rf_saved_status
  import rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSLOT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  bank_e         bank_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [NSLOT];
  logic [2:0]    sel;
  logic          valid;

  assign valid = (bank_i != BK_USR);
  assign sel   = 3'(bank_i) - 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (we_i && valid) begin
      slot_q[sel] <= wdata_i;
    end
  end

  assign rdata_o = valid ? slot_q[sel] : '0;
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import rf_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          IW       = 4,
  parameter logic [31:0] PC_RESET = 32'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode_i,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] pc_q,
  input  logic          pc_wr_en,
  input  logic [DW-1:0] pc_wr_data,
  output logic [DW-1:0] sr_rd_data,
  input  logic          sr_wr_en,
  input  logic [DW-1:0] sr_wr_data
);
  localparam int PW    = $clog2(NUM_PHYS);
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;
  localparam int WPORT = NRD;

  bank_e                      bank;
  logic [NPORT-1:0][IW-1:0]   arch_idx;
  logic [NPORT-1:0][PW-1:0]   phys_idx;
  logic [NPORT-1:0]           pc_sel;
  logic [NRD-1:0][DW-1:0]     mem_rd;
  logic                       mem_we;

  assign bank     = bank_of(mode_i);
  assign arch_idx = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    rf_index_map #(.IW(IW), .PW(PW)) u_map (
      .bank_i   (bank),
      .arch_i   (arch_idx[g]),
      .phys_o   (phys_idx[g]),
      .pc_sel_o (pc_sel[g])
    );
  end

  assign mem_we = wr_en && !rst && !pc_sel[WPORT];

  rf_gpr_mem #(.DW(DW), .DEPTH(NUM_PHYS), .PW(PW), .NRD(NRD)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (phys_idx[WPORT]),
    .wdata_i (wr_data),
    .raddr_i (phys_idx[NRD-1:0]),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= DW'(PC_RESET);
    else if (pc_wr_en) pc_q <= pc_wr_data;
  end

  assign rd_a_data = pc_sel[0] ? pc_q : mem_rd[0];
  assign rd_b_data = pc_sel[1] ? pc_q : mem_rd[1];

  rf_saved_status #(.DW(DW), .NSLOT(NUM_SAVED)) u_sr (
    .clk     (clk),
    .rst     (rst),
    .bank_i  (bank),
    .we_i    (sr_wr_en),
    .wdata_i (sr_wr_data),
    .rdata_o (sr_rd_data)
  );
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker
  import rf_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    mode_i,
  input logic [IW-1:0] rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [IW-1:0] rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] pc_q,
  input logic          pc_wr_en,
  input logic [DW-1:0] pc_wr_data,
  input logic [DW-1:0] sr_rd_data,
  input logic          sr_wr_en,
  input logic [DW-1:0] sr_wr_data
);
  localparam logic [IW-1:0] PCI = IW'(PC_IDX);

  a_r1_pc_cleared: assert property (@(posedge clk) rst |=> pc_q == '0);

  a_r2_pc_on_port_a: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == PCI |-> rd_a_data == pc_q);

  a_r2_pc_on_port_b: assert property (@(posedge clk) disable iff (rst)
    rd_b_idx == PCI |-> rd_b_data == pc_q);

  a_r3_write_then_read: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != PCI) ##1 (rd_a_idx == $past(wr_idx) && mode_i == $past(mode_i))
      |-> rd_a_data == $past(wr_data));

  a_r7_saved_write: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en && has_saved(mode_i)) ##1 (mode_i == $past(mode_i))
      |-> sr_rd_data == $past(sr_wr_data));

  a_r8_saved_zero_in_user: assert property (@(posedge clk) disable iff (rst)
    !has_saved(mode_i) |-> sr_rd_data == '0);

  a_r9_pc_load: assert property (@(posedge clk) disable iff (rst)
    pc_wr_en |=> pc_q == $past(pc_wr_data));

  a_r9_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_wr_en |=> $stable(pc_q));
endmodule

bind banked_regfile rf_checker #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .pc_q(pc_q), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
  .sr_rd_data(sr_rd_data), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  import rf_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = M_USR;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, pc_q, sr_rd_data;
  logic        wr_en = 1'b0, pc_wr_en = 1'b0, sr_wr_en = 1'b0;
  logic [31:0] wr_data = '0, pc_wr_data = '0, sr_wr_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_usr [15];
  logic [31:0] exp_fiq [7];
  logic [31:0] exp_sml [4][2];
  logic [31:0] exp_sr  [5];
  logic [4:0]  exc_modes [5];
  logic [4:0]  sml_modes [4];

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_q(pc_q), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .sr_rd_data(sr_rd_data), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic gwrite(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    mode_i = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rda(input logic [4:0] m, input logic [3:0] i, output logic [31:0] v);
    @(negedge clk);
    mode_i = m; rd_a_idx = i;
    #1 v = rd_a_data;
  endtask

  task automatic srwrite(input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    mode_i = m; sr_wr_data = d; sr_wr_en = 1'b1;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  task automatic srread(input logic [4:0] m, output logic [31:0] v);
    @(negedge clk);
    mode_i = m;
    #1 v = sr_rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk("R1 pc after reset", pc_q, 32'h0);
    for (int k = 0; k < 5; k++) begin
      srread(exc_modes[k], v);
      chk("R1 saved status after reset", v, 32'h0);
    end
  endtask

  task automatic t_user_fill();
    for (int i = 0; i < 15; i++) begin
      exp_usr[i] = 32'hA000_0000 | 32'(i);
      gwrite(M_USR, 4'(i), exp_usr[i]);
    end
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      mode_i = M_USR; rd_a_idx = 4'(i); rd_b_idx = 4'(14 - i);
      #1;
      chk("R2 port A user read", rd_a_data, exp_usr[i]);
      chk("R2 port B user read", rd_b_data, exp_usr[14-i]);
    end
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    mode_i = M_USR; rd_a_idx = 4'd3; wr_idx = 4'd3; wr_data = 32'h3333_0003; wr_en = 1'b1;
    #1 chk("R3 same-cycle read is old", rd_a_data, exp_usr[3]);
    @(posedge clk);
    #1 chk("R3 next-cycle read is new", rd_a_data, 32'h3333_0003);
    @(negedge clk) wr_en = 1'b0;
    exp_usr[3] = 32'h3333_0003;
  endtask

  task automatic t_system_share();
    logic [31:0] v;
    rda(M_SYS, 4'd5, v);
    chk("R4 system reads user r5", v, exp_usr[5]);
    exp_usr[13] = 32'h5555_000D;
    gwrite(M_SYS, 4'd13, exp_usr[13]);
    rda(M_USR, 4'd13, v);
    chk("R4 user sees system r13 write", v, exp_usr[13]);
    rda(5'b10100, 4'd14, v);
    chk("R4 unlisted mode reads user r14", v, exp_usr[14]);
    exp_usr[2] = 32'h0000_2222;
    gwrite(5'b00000, 4'd2, exp_usr[2]);
    rda(M_USR, 4'd2, v);
    chk("R4 unlisted mode writes user r2", v, exp_usr[2]);
  endtask

  task automatic t_fiq_bank();
    logic [31:0] v;
    for (int i = 8; i < 15; i++) begin
      exp_fiq[i-8] = 32'hF1F0_0000 | 32'(i);
      gwrite(M_FIQ, 4'(i), exp_fiq[i-8]);
    end
    for (int i = 0; i < 15; i++) begin
      rda(M_FIQ, 4'(i), v);
      chk("R5 fast-interrupt view", v, (i < 8) ? exp_usr[i] : exp_fiq[i-8]);
    end
    for (int i = 8; i < 15; i++) begin
      rda(M_USR, 4'(i), v);
      chk("R5 user r8-r14 untouched", v, exp_usr[i]);
    end
  endtask

  task automatic t_small_banks();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 2; j++) begin
        exp_sml[k][j] = 32'hB000_0000 | (32'(k) << 8) | 32'(13 + j);
        gwrite(sml_modes[k], 4'(13 + j), exp_sml[k][j]);
      end
    end
    for (int k = 0; k < 4; k++) begin
      rda(sml_modes[k], 4'd13, v);
      chk("R6 private r13", v, exp_sml[k][0]);
      rda(sml_modes[k], 4'd14, v);
      chk("R6 private r14", v, exp_sml[k][1]);
      rda(sml_modes[k], 4'd12, v);
      chk("R6 shared r12 from user", v, exp_usr[12]);
      rda(sml_modes[k], 4'd8, v);
      chk("R6 shared r8 is user copy", v, exp_usr[8]);
    end
    rda(M_USR, 4'd13, v);
    chk("R6 user r13 untouched", v, exp_usr[13]);
    rda(M_FIQ, 4'd14, v);
    chk("R6 fast-interrupt r14 untouched", v, exp_fiq[6]);
  endtask

  task automatic t_saved_status();
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      exp_sr[k] = 32'h5000_0000 | 32'(k * 17 + 1);
      srwrite(exc_modes[k], exp_sr[k]);
    end
    for (int k = 0; k < 5; k++) begin
      srread(exc_modes[k], v);
      chk("R7 saved status per mode", v, exp_sr[k]);
    end
    srwrite(M_USR, 32'hDEAD_BEEF);
    srread(M_USR, v);
    chk("R8 user saved status reads zero", v, 32'h0);
    srwrite(M_SYS, 32'hCAFE_F00D);
    srread(M_SYS, v);
    chk("R8 system saved status reads zero", v, 32'h0);
    for (int k = 0; k < 5; k++) begin
      srread(exc_modes[k], v);
      chk("R8 user/system write ignored", v, exp_sr[k]);
    end
  endtask

  task automatic t_pc();
    logic [31:0] v;
    @(negedge clk);
    pc_wr_data = 32'h0000_1004; pc_wr_en = 1'b1;
    #1 chk("R9 pc not yet loaded", pc_q, 32'h0);
    @(posedge clk);
    #1 chk("R9 pc loaded", pc_q, 32'h0000_1004);
    @(negedge clk);
    pc_wr_en = 1'b0; mode_i = M_USR; rd_b_idx = 4'd15;
    #1 chk("R2 index 15 returns pc", rd_b_data, 32'h0000_1004);
    gwrite(M_FIQ, 4'd15, 32'hFFFF_FFFF);
    gwrite(M_USR, 4'd15, 32'hEEEE_EEEE);
    chk("R9 general write to 15 keeps pc", pc_q, 32'h0000_1004);
    rda(M_FIQ, 4'd8, v);
    chk("R9 general write to 15 spares banks", v, exp_fiq[0]);
    rda(M_USR, 4'd0, v);
    chk("R9 general write to 15 spares r0", v, exp_usr[0]);
  endtask

  initial begin
    exc_modes = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    sml_modes = '{M_IRQ, M_SVC, M_ABT, M_UND};
    t_reset();
    t_user_fill();
    t_same_cycle();
    t_system_share();
    t_fiq_bank();
    t_small_banks();
    t_saved_status();
    t_pc();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule